// File: doc/BRIEF.md
# Page-Buffered Write Load Controller

This block sits between a host that drives SRAM-style active-low strobes (chip enable, output enable, write enable) and a behavioural model of a slow nonvolatile array. The strobes are sampled in the system clock domain. A qualified write strobe closes a byte load. The block gathers up to 64 such loads into a one-page buffer and keeps a valid flag for each byte. The first load of a period fixes the page. Later loads must hit that same page, and each must come within a byte-load window of the last accepted load.

When the window runs out, the load period closes and a fixed-length programming interval begins. The block reports busy for that whole interval. At its end, the bytes that were loaded, and only those, are committed to the array in one cycle. A host can read the array back through the same strobes. A power-up delay after reset, a minimum strobe width and the busy interval all block writes. A load aimed at a different page is dropped and sets a sticky error flag.

Top module: `pgw_ctrl`

## Requirements
- R1: A byte load happens only while ce_n=0, we_n=0 and oe_n=1 all hold together. A strobe that has oe_n=0 or ce_n=1 loads nothing.
- R2: The address is taken in the first clock cycle of the combined write strobe. The data is taken in the last cycle before the strobe releases. Address changes later in the strobe, and data values earlier in it, have no effect.
- R3: Address bits [14:6] form the page number and bits [5:0] the byte offset. page_addr shows the full page number of the open period. The array holds NUM_PAGES pages, and page p is stored in slot p mod NUM_PAGES (so page 9 and page 1 share a slot when NUM_PAGES=8).
- R4: The load period closes, and busy rises, BLC_CYC cycles after the last accepted load takes effect. With the bench's sampling, busy is first seen BLC_CYC+2 falling edges after the strobe is released. Any accepted load restarts the window.
- R5: Bytes may be loaded in any order. A byte loaded twice takes the later value. byte_mask bit i is set once offset i is loaded, and bits never clear during a period. Up to 64 bytes load in one period. Array bytes whose offset was not loaded keep their earlier contents.
- R6: busy stays high for exactly TWC_CYC cycles. The loaded bytes can be read back once busy falls.
- R7: A write strobe that is active for fewer than GLITCH_CYC sampled cycles is ignored. A strobe of exactly GLITCH_CYC cycles is accepted.
- R8: During a period, a load whose page differs from page_addr is ignored and sets page_err. page_err stays set until the next period opens, and it clears on that opening load.
- R9: Write strobes are ignored while busy is high. byte_mask does not change during busy, and no new period opens from such a strobe.
- R10: Writes are ignored until PWRUP_CYC cycles after reset is released.
- R11: After reset, busy=0, byte_mask=0, page_err=0, page_addr=0, and every array byte reads 0.
- R12: dout shows the stored byte at addr while ce_n=0, oe_n=0 and we_n=1. At all other times dout is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, 0 when not reading |
| busy | output | 1 | Programming interval in progress |
| page_addr | output | ADDR_W-OFFS_W | Page number of the current or last load period |
| byte_mask | output | 2**OFFS_W | Offsets loaded in the current or last period |
| page_err | output | 1 | Sticky flag for an ignored off-page load |

## Verification
A loader stuck in the wrong state shows up first on busy. A window counter that is off by one moves the busy rising edge by one cycle, and that is seen on the first period of any test. A programming counter that is off by one changes the busy width. A corrupted buffer or a corrupted mask stays hidden until the end of the busy interval. The bench therefore reads back both loaded bytes and untouched bytes right after each commit. A wrong page register shows up at once on page_addr, and later as data appearing in the wrong array slot.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_OPEN = 2'd1,
    LD_PROG = 2'd2
  } ld_state_e;
endpackage

// File: rtl/pgw_strobe.sv
// Qualifies write strobes: power-up hold-off, write inhibit, minimum width.
module pgw_strobe #(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int GLITCH_CYC = 3,
  parameter int PWRUP_CYC  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              busy,
  output logic              ld_v,
  output logic [ADDR_W-1:0] ld_addr,
  output logic [DATA_W-1:0] ld_data,
  output logic              pwr_ready
);
  localparam int LEN_W = $clog2(GLITCH_CYC + 1) + 1;
  localparam int PW_W  = $clog2(PWRUP_CYC + 1) + 1;

  function automatic logic wide_enough(input logic [LEN_W-1:0] n);
    return n >= LEN_W'(GLITCH_CYC);
  endfunction

  logic [PW_W-1:0]   pwr_cnt;
  logic [LEN_W-1:0]  len_q;
  logic              act_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] din_q;
  logic              strobe_on;

  assign pwr_ready = (pwr_cnt == PW_W'(PWRUP_CYC));
  assign strobe_on = !ce_n && !we_n && oe_n && pwr_ready && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_cnt <= '0;
    end else if (!pwr_ready) begin
      pwr_cnt <= pwr_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      len_q  <= '0;
      addr_q <= '0;
      din_q  <= '0;
      ld_v   <= 1'b0;
    end else begin
      act_q <= strobe_on;
      ld_v  <= 1'b0;
      if (strobe_on) begin
        if (!act_q) begin
          addr_q <= addr;
          len_q  <= LEN_W'(1);
        end else if (!wide_enough(len_q)) begin
          len_q <= len_q + 1'b1;
        end
        din_q <= din;
      end else begin
        if (act_q && wide_enough(len_q)) ld_v <= 1'b1;
        len_q <= '0;
      end
    end
  end

  assign ld_addr = addr_q;
  assign ld_data = din_q;
endmodule

// File: rtl/pgw_loader.sv
// Page buffer, byte mask, byte-load window and programming timer.
module pgw_loader
  import pgw_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 8,
  parameter int OFFS_W  = 6,
  parameter int BLC_CYC = 50,
  parameter int TWC_CYC = 200
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ld_v,
  input  logic [ADDR_W-1:0]             ld_addr,
  input  logic [DATA_W-1:0]             ld_data,
  output logic                          busy,
  output logic                          loading,
  output logic                          open_evt,
  output logic                          commit,
  output logic [ADDR_W-OFFS_W-1:0]      page_q,
  output logic [(1<<OFFS_W)-1:0]        mask_q,
  output logic                          err_q,
  output logic [(1<<OFFS_W)*DATA_W-1:0] buf_flat
);
  localparam int PAGE_BYTES = 1 << OFFS_W;
  localparam int PG_W       = ADDR_W - OFFS_W;
  localparam int BW         = $clog2(BLC_CYC + 1);
  localparam int TW         = $clog2(TWC_CYC + 1);

  function automatic logic [PG_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFFS_W];
  endfunction

  function automatic logic [OFFS_W-1:0] offs_of(input logic [ADDR_W-1:0] a);
    return a[OFFS_W-1:0];
  endfunction

  function automatic logic [PAGE_BYTES-1:0] lane_bit(input logic [OFFS_W-1:0] o);
    logic [PAGE_BYTES-1:0] v;
    v    = '0;
    v[o] = 1'b1;
    return v;
  endfunction

  ld_state_e         st;
  logic [BW-1:0]     blc_cnt;
  logic [TW-1:0]     twc_cnt;
  logic [DATA_W-1:0] pbuf [PAGE_BYTES];
  logic              same_page;
  logic              take;
  logic              off_evt;
  logic              win_end;

  assign same_page = (page_of(ld_addr) == page_q);
  assign open_evt  = ld_v && (st == LD_IDLE);
  assign take      = open_evt || (ld_v && (st == LD_OPEN) && same_page);
  assign off_evt   = ld_v && (st == LD_OPEN) && !same_page;
  assign win_end   = (blc_cnt == BW'(BLC_CYC - 1));
  assign commit    = (st == LD_PROG) && (twc_cnt == TW'(TWC_CYC - 1));
  assign busy      = (st == LD_PROG);
  assign loading   = (st == LD_OPEN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= LD_IDLE;
      blc_cnt <= '0;
      twc_cnt <= '0;
      page_q  <= '0;
      mask_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (st)
        LD_IDLE: begin
          if (ld_v) begin
            st      <= LD_OPEN;
            page_q  <= page_of(ld_addr);
            mask_q  <= lane_bit(offs_of(ld_addr));
            err_q   <= 1'b0;
            blc_cnt <= '0;
          end
        end
        LD_OPEN: begin
          if (off_evt) err_q <= 1'b1;
          if (take) begin
            mask_q  <= mask_q | lane_bit(offs_of(ld_addr));
            blc_cnt <= '0;
          end else if (win_end) begin
            st      <= LD_PROG;
            twc_cnt <= '0;
          end else begin
            blc_cnt <= blc_cnt + 1'b1;
          end
        end
        LD_PROG: begin
          if (commit) st <= LD_IDLE;
          else twc_cnt <= twc_cnt + 1'b1;
        end
        default: st <= LD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= '0;
    end else if (take) begin
      pbuf[offs_of(ld_addr)] <= ld_data;
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_flat
    assign buf_flat[g*DATA_W +: DATA_W] = pbuf[g];
  end
endmodule

// File: rtl/pgw_array.sv
// Behavioural array: one storage lane per byte offset, masked page commit.
module pgw_array #(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int OFFS_W    = 6,
  parameter int NUM_PAGES = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          commit,
  input  logic [ADDR_W-OFFS_W-1:0]      commit_page,
  input  logic [(1<<OFFS_W)-1:0]        commit_mask,
  input  logic [(1<<OFFS_W)*DATA_W-1:0] commit_data,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic [DATA_W-1:0]             rd_data
);
  localparam int PAGE_BYTES = 1 << OFFS_W;
  localparam int PG_W       = ADDR_W - OFFS_W;
  localparam int IDX_W      = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;

  function automatic logic [IDX_W-1:0] slot_of(input logic [PG_W-1:0] p);
    return IDX_W'(p % PG_W'(NUM_PAGES));
  endfunction

  logic [IDX_W-1:0]  wr_slot;
  logic [IDX_W-1:0]  rd_slot;
  logic [DATA_W-1:0] lane_out [PAGE_BYTES];

  assign wr_slot = slot_of(commit_page);
  assign rd_slot = slot_of(rd_addr[ADDR_W-1:OFFS_W]);

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
    logic [DATA_W-1:0] cells [NUM_PAGES];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int s = 0; s < NUM_PAGES; s++) cells[s] <= '0;
      end else if (commit && commit_mask[g]) begin
        cells[wr_slot] <= commit_data[g*DATA_W +: DATA_W];
      end
    end
    assign lane_out[g] = cells[rd_slot];
  end

  assign rd_data = rd_en ? lane_out[rd_addr[OFFS_W-1:0]] : '0;
endmodule

// File: rtl/pgw_ctrl.sv
module pgw_ctrl #(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int OFFS_W     = 6,
  parameter int NUM_PAGES  = 8,
  parameter int BLC_CYC    = 50,
  parameter int TWC_CYC    = 200,
  parameter int GLITCH_CYC = 3,
  parameter int PWRUP_CYC  = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ce_n,
  input  logic                     oe_n,
  input  logic                     we_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        din,
  output logic [DATA_W-1:0]        dout,
  output logic                     busy,
  output logic [ADDR_W-OFFS_W-1:0] page_addr,
  output logic [(1<<OFFS_W)-1:0]   byte_mask,
  output logic                     page_err
);
  localparam int PAGE_BYTES = 1 << OFFS_W;

  logic                         ld_v;
  logic [ADDR_W-1:0]            ld_addr;
  logic [DATA_W-1:0]            ld_data;
  logic                         pwr_ready;
  logic                         loading;
  logic                         open_evt;
  logic                         commit;
  logic [PAGE_BYTES*DATA_W-1:0] buf_flat;
  logic                         rd_en;

  assign rd_en = !ce_n && !oe_n && we_n;

  pgw_strobe #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .GLITCH_CYC(GLITCH_CYC), .PWRUP_CYC(PWRUP_CYC)
  ) u_strobe (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .busy(busy),
    .ld_v(ld_v), .ld_addr(ld_addr), .ld_data(ld_data), .pwr_ready(pwr_ready)
  );

  pgw_loader #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFS_W(OFFS_W),
    .BLC_CYC(BLC_CYC), .TWC_CYC(TWC_CYC)
  ) u_loader (
    .clk(clk), .rst_n(rst_n), .ld_v(ld_v), .ld_addr(ld_addr), .ld_data(ld_data),
    .busy(busy), .loading(loading), .open_evt(open_evt), .commit(commit),
    .page_q(page_addr), .mask_q(byte_mask), .err_q(page_err), .buf_flat(buf_flat)
  );

  pgw_array #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFS_W(OFFS_W), .NUM_PAGES(NUM_PAGES)
  ) u_array (
    .clk(clk), .rst_n(rst_n), .commit(commit), .commit_page(page_addr),
    .commit_mask(byte_mask), .commit_data(buf_flat),
    .rd_en(rd_en), .rd_addr(addr), .rd_data(dout)
  );
endmodule

// File: rtl/pgw_ctrl_chk.sv
module pgw_ctrl_chk #(
  parameter int TWC_CYC    = 200,
  parameter int PAGE_BYTES = 64
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  busy,
  input logic                  loading,
  input logic                  ld_v,
  input logic                  open_evt,
  input logic                  pwr_ready,
  input logic                  page_err,
  input logic [PAGE_BYTES-1:0] byte_mask
);
  localparam int RW = $clog2(TWC_CYC + 1) + 1;
  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n) run <= '0;
    else if (busy) run <= run + 1'b1;
    else run <= '0;
  end

  a_r6_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run == RW'(TWC_CYC));
  a_r6_busy_cap: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run < RW'(TWC_CYC));
  a_r9_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(byte_mask));
  a_r5_mask_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (loading && $past(loading)) |-> ((byte_mask & $past(byte_mask)) == $past(byte_mask)));
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (page_err && !open_evt) |=> page_err);
  a_r8_err_open: assert property (@(posedge clk) disable iff (!rst_n)
    open_evt |=> !page_err);
  a_r10_quiet_early: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ready |=> !ld_v);
  a_r11_state_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && loading));
endmodule

bind pgw_ctrl pgw_ctrl_chk #(.TWC_CYC(TWC_CYC), .PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .loading(loading), .ld_v(ld_v),
  .open_evt(open_evt), .pwr_ready(pwr_ready), .page_err(page_err),
  .byte_mask(byte_mask)
);

// File: tb/pgw_ctrl_test.sv
`timescale 1ns/1ps
module pgw_ctrl_test;
  localparam int BLC = 40;
  localparam int TWC = 100;
  localparam int GL  = 3;
  localparam int PW  = 30;
  localparam int NP  = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [14:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        busy;
  logic [8:0]  page_addr;
  logic [63:0] byte_mask;
  logic        page_err;

  int nvec = 0;
  int nbad = 0;
  logic [7:0]  model [NP*64];
  logic [7:0]  pdat [64];
  logic [63:0] pval;
  logic [8:0]  ppage;

  always #10 clk = ~clk;

  pgw_ctrl #(.NUM_PAGES(NP), .BLC_CYC(BLC), .TWC_CYC(TWC),
             .GLITCH_CYC(GL), .PWRUP_CYC(PW)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .busy(busy),
    .page_addr(page_addr), .byte_mask(byte_mask), .page_err(page_err));

  function automatic int slot(input logic [14:0] a);
    return ((int'(a) / 64) % NP) * 64 + (int'(a) % 64);
  endfunction

  task automatic expect_eq(input string tag, input logic [63:0] got, input logic [63:0] want);
    nvec++;
    if (got !== want) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", tag, got, want);
    end
  endtask

  // Drives one strobe of len cycles; address scrambled after cycle 1, data valid only in the last cycle.
  task automatic strobe(input logic [14:0] a, input logic [7:0] d, input int len,
                        input bit oe_low, input bit ce_high, input bit keep);
    @(negedge clk);
    addr = a; din = (len == 1) ? d : ~d;
    ce_n = ce_high; we_n = 1'b0; oe_n = !oe_low;
    for (int k = 2; k <= len; k++) begin
      @(negedge clk);
      addr = a ^ 15'h7fff;
      if (k == len) din = d;
    end
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    repeat (3) @(negedge clk);
    if (keep) begin
      ppage = a[14:6];
      pdat[a[5:0]] = d;
      pval[a[5:0]] = 1'b1;
    end
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d);
    strobe(a, d, 4, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic rd(input logic [14:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    #2 v = dout;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic rd_chk(input string tag, input logic [14:0] a);
    logic [7:0] v;
    rd(a, v);
    expect_eq(tag, {56'd0, v}, {56'd0, model[slot(a)]});
  endtask

  task automatic apply_pending();
    for (int i = 0; i < 64; i++)
      if (pval[i]) model[slot({ppage, 6'(i)})] = pdat[i];
    pval = '0;
  endtask

  task automatic drop_pending();
    pval = '0;
  endtask

  task automatic wait_done(output int lat, output int wid);
    lat = 0;
    while (!busy && lat < 5000) begin @(negedge clk); lat++; end
    wid = (busy) ? 1 : 0;
    while (busy && wid < 5000) begin
      @(negedge clk);
      if (busy) wid++;
    end
    apply_pending();
  endtask

  task automatic quiet(input string tag, input int n);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (busy) seen = 1;
    end
    expect_eq(tag, {63'd0, seen}, 64'd0);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    expect_eq("R11 busy", {63'd0, busy}, 0);
    expect_eq("R11 mask", byte_mask, 0);
    expect_eq("R11 err", {63'd0, page_err}, 0);
    expect_eq("R11 page", {55'd0, page_addr}, 0);
    rd(15'h2345, v);
    expect_eq("R11 array zero", {56'd0, v}, 0);
  endtask

  task automatic t_pwrup();
    strobe(15'h0123, 8'h5A, 4, 1'b0, 1'b0, 1'b0);
    quiet("R10 no busy before ready", BLC + 20);
    expect_eq("R10 mask", byte_mask, 0);
    rd_chk("R10 array", 15'h0123);
  endtask

  task automatic t_single();
    int lat, wid;
    wr(15'h1A45, 8'hC3);
    expect_eq("R3 page_addr", {55'd0, page_addr}, 64'h69);
    expect_eq("R3 mask offs5", byte_mask, 64'h20);
    wait_done(lat, wid);
    expect_eq("R4 close latency", lat, BLC - 1);
    expect_eq("R6 busy width", wid, TWC);
    rd_chk("R2 data at release", 15'h1A45);
    rd_chk("R2 addr at start", 15'h1A45 ^ 15'h7fff);
    begin
      logic [7:0] v;
      @(negedge clk);
      addr = 15'h1A45; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
      #2 v = dout;
      @(negedge clk); ce_n = 1'b1;
      expect_eq("R12 no read with oe high", {56'd0, v}, 0);
    end
  endtask

  task automatic t_window();
    int lat, wid;
    wr(15'h0081, 8'h11);
    quiet("R4 window open", BLC - 10);
    wr(15'h0082, 8'h22);
    wait_done(lat, wid);
    expect_eq("R4 window restart", lat, BLC - 1);
    rd_chk("R4 first byte", 15'h0081);
    rd_chk("R4 second byte", 15'h0082);
  endtask

  task automatic t_page();
    int lat, wid;
    wr(15'h0CD0, 8'h77);
    wr(15'h0CD1, 8'h10);
    wait_done(lat, wid);
    wr(15'h0CFF, 8'hA1);
    wr(15'h0CC0, 8'hB2);
    wr(15'h0CD1, 8'hC4);
    wr(15'h0CD1, 8'hD5);
    expect_eq("R5 mask", byte_mask, (64'd1 << 63) | 64'd1 | (64'd1 << 17));
    wait_done(lat, wid);
    rd_chk("R5 offs63", 15'h0CFF);
    rd_chk("R5 offs0", 15'h0CC0);
    rd_chk("R5 rewrite newest", 15'h0CD1);
    rd_chk("R5 untouched kept", 15'h0CD0);
    for (int i = 0; i < 64; i++) wr(15'h0100 + 15'(i), 8'(i * 3 + 1));
    expect_eq("R5 full page mask", byte_mask, {64{1'b1}});
    wait_done(lat, wid);
    rd_chk("R5 full first", 15'h0100);
    rd_chk("R5 full mid", 15'h011F);
    rd_chk("R5 full last", 15'h013F);
  endtask

  task automatic t_offpage();
    int lat, wid;
    wr(15'h0203, 8'h31);
    strobe(15'h0243, 8'h32, 4, 1'b0, 1'b0, 1'b0);
    expect_eq("R8 err set", {63'd0, page_err}, 1);
    expect_eq("R8 mask kept", byte_mask, 64'h8);
    expect_eq("R8 page kept", {55'd0, page_addr}, 64'h8);
    wait_done(lat, wid);
    expect_eq("R8 err sticky", {63'd0, page_err}, 1);
    rd_chk("R8 offpage not written", 15'h0243);
    wr(15'h0244, 8'h33);
    expect_eq("R8 err cleared", {63'd0, page_err}, 0);
    wait_done(lat, wid);
  endtask

  task automatic t_glitch();
    int lat, wid;
    logic [63:0] m0;
    m0 = byte_mask;
    strobe(15'h0305, 8'h44, GL - 1, 1'b0, 1'b0, 1'b0);
    quiet("R7 short pulse no busy", BLC + 10);
    expect_eq("R7 short pulse mask", byte_mask, m0);
    rd_chk("R7 short pulse data", 15'h0305);
    strobe(15'h0305, 8'h45, GL, 1'b0, 1'b0, 1'b1);
    wait_done(lat, wid);
    expect_eq("R7 min pulse busy", wid, TWC);
    rd_chk("R7 min pulse data", 15'h0305);
  endtask

  task automatic t_inhibit();
    logic [63:0] m0;
    m0 = byte_mask;
    strobe(15'h0306, 8'h55, 5, 1'b1, 1'b0, 1'b0);
    strobe(15'h0307, 8'h56, 5, 1'b0, 1'b1, 1'b0);
    quiet("R1 inhibited no busy", BLC + 10);
    expect_eq("R1 inhibited mask", byte_mask, m0);
    rd_chk("R1 oe low no write", 15'h0306);
    rd_chk("R1 ce high no write", 15'h0307);
  endtask

  task automatic t_busy();
    int lat, wid;
    wr(15'h0408, 8'h66);
    lat = 0;
    while (!busy && lat < 5000) begin @(negedge clk); lat++; end
    strobe(15'h0409, 8'h67, 4, 1'b0, 1'b0, 1'b0);
    wait_done(lat, wid);
    expect_eq("R9 mask unchanged", byte_mask, 64'h100);
    quiet("R9 no new period", BLC + 10);
    rd_chk("R9 ignored byte", 15'h0409);
    rd_chk("R9 real byte", 15'h0408);
  endtask

  task automatic t_alias();
    int lat, wid;
    wr(15'h0245, 8'h9E);
    expect_eq("R3 full page number", {55'd0, page_addr}, 64'h9);
    wait_done(lat, wid);
    rd_chk("R3 alias read page1", 15'h0045);
    rd_chk("R3 alias read page9", 15'h0245);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nvec++; nbad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NP*64; i++) model[i] = 8'h00;
    pval = '0; ppage = '0;
    for (int i = 0; i < 64; i++) pdat[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pwrup();
    t_single();
    t_window();
    t_page();
    t_offpage();
    t_glitch();
    t_inhibit();
    t_busy();
    t_alias();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule